// File: doc/BRIEF.md
# Ready/Value Polling Mailbox

This block is a one-slot mailbox. A device-side producer uses it to hand a single data word to a processor that polls for it. The processor reaches the block through a small memory-mapped slave port. Each request has an address, a write enable and write data, and gets an acknowledge with read data exactly one cycle later. The device side has a value input, a push strobe and a busy output.

The slot is a two-state machine. In SLOT_EMPTY the ready flag reads 0 and the device may push. A push loads the value word and takes the FILL transition to SLOT_FULL on the same clock edge, so the flag and the word always become visible together. In SLOT_FULL the ready flag reads 1 and busy is high. The processor reads the word and then writes zero to the flag. That write takes the DRAIN transition back to SLOT_EMPTY. A push that arrives while the slot is full is refused and sets a sticky overflow bit.

The block occupies three word addresses above a base address parameter (default 0x8000_0000):

| Offset | Content |
|---|---|
| 0x100 | Ready flag in bit 0 |
| 0x104 | Value word |
| 0x108 | Overflow flag in bit 0 |

Top module: `ready_value_mailbox`

## Requirements
- R1: After reset, the ready flag, the value word and the overflow flag all read 0, and dev_busy is low.
- R2: A dev_push while the slot is empty loads dev_value. From the next cycle, a read of BASE+0x100 returns 1 in bit 0 (upper bits 0).
- R3: Whenever the ready flag rises, the value word already holds the pushed value. A read of BASE+0x104 never pairs ready=1 with an older word.
- R4: A dev_push while the slot is full is refused. The value word is unchanged, and bit 0 of BASE+0x108 reads 1 from the next cycle.
- R5: A bus write of all-zero data to BASE+0x100 while the slot is full empties it. A write of any nonzero data there has no effect.
- R6: When a zero write to BASE+0x100 and a dev_push happen in the same cycle on a full slot, the clear wins. The slot is empty next cycle, the pushed word is discarded, the overflow flag is set and dev_busy falls.
- R7: A bus write to BASE+0x104 is ignored. Only the device port loads the value word.
- R8: Every bus request, read or write, gets bus_ack high for exactly one cycle, in the cycle after the request. Read data for that request appears on bus_rdata in the same cycle as bus_ack.
- R9: A read of any address other than the three mapped ones returns 0, and writes to such addresses change nothing.
- R10: dev_busy is high exactly while the ready flag reads 1.
- R11: Once set, the overflow flag stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | Response strobe, one cycle after the request |
| bus_rdata | output | DATA_W | Read data, valid with bus_ack |
| dev_value | input | DATA_W | Word offered by the device |
| dev_push | input | 1 | Device deposit strobe |
| dev_busy | output | 1 | Slot full: a push now is refused |

## Verification
A wrong state register shows up at the very next cycle as a dev_busy level that disagrees with the reference model. It shows up again on the next poll of the ready address, which answers one cycle after the request. If the value word loads at the wrong moment, or loads from a bus write, the error stays hidden until the processor reads offset 0x104. The bench therefore reads the word after every fill, after every refused push and after every write to the value address. A lost or spurious overflow flag can only be seen by reading offset 0x108. Because the flag never clears, the first error in it persists and is caught at the next such read.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [0:0] {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    localparam int unsigned OFS_READY = 32'h100;
    localparam int unsigned OFS_VALUE = 32'h104;
    localparam int unsigned OFS_OVFL  = 32'h108;

    typedef struct packed {
        logic ready;
        logic value;
        logic ovfl;
    } reg_sel_t;

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int unsigned       ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = 'h8000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    localparam logic [ADDR_W-1:0] A_READY = BASE + ADDR_W'(OFS_READY);
    localparam logic [ADDR_W-1:0] A_VALUE = BASE + ADDR_W'(OFS_VALUE);
    localparam logic [ADDR_W-1:0] A_OVFL  = BASE + ADDR_W'(OFS_OVFL);

    always_comb begin
        sel       = '0;
        sel.ready = (addr == A_READY);
        sel.value = (addr == A_VALUE);
        sel.ovfl  = (addr == A_OVFL);
    end

endmodule

// File: rtl/mbox_slot.sv
module mbox_slot
    import mbox_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_value,
    input  logic              clr_req,
    output logic              ready,
    output logic [DATA_W-1:0] value,
    output logic              ovfl
);

    slot_state_e       state_q, state_d;
    logic [DATA_W-1:0] value_q;
    logic              ovfl_q;
    logic              load;
    logic              refuse;

    // next-state logic: FILL and DRAIN transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (push)    state_d = SLOT_FULL;
            SLOT_FULL:  if (clr_req) state_d = SLOT_EMPTY;
            default:                 state_d = SLOT_EMPTY;
        endcase
    end

    assign load   = (state_q == SLOT_EMPTY) && push;
    assign refuse = (state_q == SLOT_FULL)  && push;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            value_q <= '0;
            ovfl_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load)   value_q <= push_value;
            if (refuse) ovfl_q  <= 1'b1;
        end
    end

    // output process
    always_comb begin
        ready = (state_q == SLOT_FULL);
        value = value_q;
        ovfl  = ovfl_q;
    end

    p_fill_word_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (value_q == $past(push_value)));

    p_refused_keeps_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && push) |=> $stable(value_q));

    p_refused_sets_ovfl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && push) |=> ovfl_q);

    p_only_push_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ready && push) |=> $stable(value_q));

    p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && clr_req) |=> !ready);

    p_ovfl_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ovfl_q |=> ovfl_q);

endmodule

// File: rtl/mbox_readback.sv
module mbox_readback
    import mbox_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  reg_sel_t          sel,
    input  logic              ready,
    input  logic [DATA_W-1:0] value,
    input  logic              ovfl,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] rd_next;
    logic              ack_q;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        rd_next = '0;
        if (req && !we) begin
            if (sel.ready)      rd_next[0] = ready;
            else if (sel.value) rd_next    = value;
            else if (sel.ovfl)  rd_next[0] = ovfl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q   <= req;
            rdata_q <= rd_next;
        end
    end

    assign ack   = ack_q;
    assign rdata = rdata_q;

    p_ack_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ack);

    p_no_spurious_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !ack);

    p_unmapped_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && !sel.ready && !sel.value && !sel.ovfl) |=> (rdata == '0));

endmodule

// File: rtl/ready_value_mailbox.sv
module ready_value_mailbox
    import mbox_pkg::*;
#(
    parameter int unsigned       ADDR_W = 32,
    parameter int unsigned       DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = 'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] dev_value,
    input  logic              dev_push,
    output logic              dev_busy
);

    reg_sel_t          sel;
    logic              clr_req;
    logic              ready;
    logic [DATA_W-1:0] value;
    logic              ovfl;

    mbox_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    // only an all-zero write to the flag address hands the slot back
    assign clr_req = bus_req && bus_we && sel.ready && (bus_wdata == '0);

    mbox_slot #(.DATA_W(DATA_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (dev_push),
        .push_value (dev_value),
        .clr_req    (clr_req),
        .ready      (ready),
        .value      (value),
        .ovfl       (ovfl)
    );

    mbox_readback #(.DATA_W(DATA_W)) u_readback (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (bus_req),
        .we    (bus_we),
        .sel   (sel),
        .ready (ready),
        .value (value),
        .ovfl  (ovfl),
        .ack   (bus_ack),
        .rdata (bus_rdata)
    );

    assign dev_busy = ready;

    p_nonzero_write_keeps_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && bus_req && bus_we && (bus_wdata != '0) && !(sel.ready && bus_wdata == '0)) |=> ready);

endmodule

// File: tb/sim_ready_value_mailbox.sv
module sim_ready_value_mailbox;

    localparam int  PERIOD    = 10;
    localparam int  WD_CYCLES = 100000;
    localparam logic [31:0] BASE    = 32'h8000_0000;
    localparam logic [31:0] A_READY = BASE + 32'h100;
    localparam logic [31:0] A_VALUE = BASE + 32'h104;
    localparam logic [31:0] A_OVFL  = BASE + 32'h108;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic [31:0] dev_value = '0;
    logic        dev_push = 1'b0;
    logic        dev_busy;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit          m_ready = 0;
    logic [31:0] m_value = '0;
    bit          m_ovfl = 0;

    always #(PERIOD/2) clk = ~clk;

    ready_value_mailbox u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .dev_value(dev_value), .dev_push(dev_push),
        .dev_busy(dev_busy)
    );

    function automatic logic [31:0] exp_read(input logic [31:0] a);
        if (a == A_READY) return {31'b0, m_ready};
        if (a == A_VALUE) return m_value;
        if (a == A_OVFL)  return {31'b0, m_ovfl};
        return 32'h0;
    endfunction

    function automatic string tag_for(input logic [31:0] a);
        if (a == A_READY) return "R5";
        if (a == A_VALUE) return "R7";
        if (a == A_OVFL)  return "R11";
        return "R9";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock cycle with full reference-model update and output checks
    task automatic cyc(input bit rq, input bit we, input logic [31:0] a,
                       input logic [31:0] wd, input bit ps, input logic [31:0] dv,
                       input string tag);
        bit          n_ready;
        logic [31:0] n_value;
        bit          n_ovfl;
        bit          clr;
        logic [31:0] e_rd;
        @(negedge clk);
        bus_req = rq; bus_we = we; bus_addr = a; bus_wdata = wd;
        dev_push = ps; dev_value = dv;
        clr = rq && we && (a == A_READY) && (wd == 32'h0);
        n_ready = m_ready; n_value = m_value; n_ovfl = m_ovfl;
        if (m_ready) begin
            if (ps)  n_ovfl  = 1;
            if (clr) n_ready = 0;
        end else if (ps) begin
            n_ready = 1;
            n_value = dv;
        end
        e_rd = exp_read(a);
        @(posedge clk);
        #1;
        m_ready = n_ready; m_value = n_value; m_ovfl = n_ovfl;
        check("R10 busy", {31'b0, dev_busy}, {31'b0, m_ready});
        check("R8 ack", {31'b0, bus_ack}, {31'b0, rq});
        if (rq && !we) check(tag, bus_rdata, e_rd);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 32'h0, 32'h0, 0, 32'h0, tag);
    endtask

    task automatic rd(input logic [31:0] a, input string tag);
        cyc(1, 0, a, 32'h0, 0, 32'h0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 busy", {31'b0, dev_busy}, 32'h0);
        rd(A_READY, "R1");
        rd(A_VALUE, "R1");
        rd(A_OVFL,  "R1");
        // R2: fill, then poll
        cyc(0, 0, 32'h0, 32'h0, 1, 32'hA5A5_1234, "R2");
        rd(A_READY, "R2");
        rd(A_VALUE, "R3");
        // R4: push while full is refused
        cyc(0, 0, 32'h0, 32'h0, 1, 32'h0000_1111, "R4");
        rd(A_VALUE, "R4");
        rd(A_OVFL,  "R4");
        // R7: bus write to value ignored
        cyc(1, 1, A_VALUE, 32'hDEAD_BEEF, 0, 32'h0, "R7");
        rd(A_VALUE, "R7");
        // R5: nonzero write keeps slot, zero write drains it
        cyc(1, 1, A_READY, 32'h1, 0, 32'h0, "R5");
        rd(A_READY, "R5");
        cyc(1, 1, A_READY, 32'h0, 0, 32'h0, "R5");
        rd(A_READY, "R5");
        check("R5 busy low", {31'b0, dev_busy}, 32'h0);
        // R9: unmapped and out-of-region accesses
        cyc(1, 1, BASE + 32'h10C, 32'hFFFF_FFFF, 0, 32'h0, "R9");
        rd(BASE + 32'h10C, "R9");
        rd(32'h0000_0104, "R9");
        rd(A_READY, "R9");
        // R6: clear and push in the same cycle
        cyc(0, 0, 32'h0, 32'h0, 1, 32'h0000_0077, "R2");
        check("R6 busy before", {31'b0, dev_busy}, 32'h1);
        cyc(1, 1, A_READY, 32'h0, 1, 32'h0000_0099, "R6");
        check("R6 busy after", {31'b0, dev_busy}, 32'h0);
        rd(A_READY, "R6");
        rd(A_VALUE, "R6");
        rd(A_OVFL,  "R6");
        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            int unsigned pick;
            logic [31:0] a;
            bit rq, we, ps;
            logic [31:0] wd;
            pick = $urandom_range(0, 9);
            case (pick)
                0, 1, 2: a = A_READY;
                3, 4, 5: a = A_VALUE;
                6:       a = A_OVFL;
                7:       a = BASE + ($urandom_range(0, 63) << 2);
                8:       a = $urandom();
                default: a = A_READY;
            endcase
            rq = ($urandom_range(0, 3) != 0);
            we = ($urandom_range(0, 2) == 0);
            wd = ($urandom_range(0, 1) == 0) ? 32'h0 : $urandom();
            ps = ($urandom_range(0, 3) == 0);
            cyc(rq, we, a, wd, ps, $urandom(), tag_for(a));
        end
        idle("R10");
        rd(A_OVFL, "R11");
        finish_run();
    end

endmodule